// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block sits on the host side of a serial configuration memory and turns one command request into the complete chip-select-framed serial exchange. A request carries a command select, a 24-bit address and a byte count. The sequencer looks the select up in a small per-command table, which gives the opcode, the number of address bytes, the number of dummy bytes, the data direction and the serial clock class. It then shifts everything out on a mode-0 serial link. Outgoing data comes from a valid/ready write stream. Bytes read back are presented on a valid/ready read stream, and the serial clock pauses while that stream is backpressured.

For commands that change the memory, the sequencer first sends a write-enable command in a transaction of its own. After the main command, it repeatedly reads the status register until the busy bit clears. The single `done` pulse therefore marks the point where the memory is ready again. Chip select stays high for a minimum number of system cycles between any two transactions.

Top module: `sflash_cmd_seq`

## Requirements
- R1: Select codes 0..10 map to opcodes 06h, 04h, 05h, 03h, ABh, 0Bh, 01h, 02h, C7h, D8h and 9Fh in that order. The opcode is the first byte of its transaction and is shifted out MSB first.
- R2: Opcodes 03h, 0Bh, 02h and D8h are followed by three address bytes: bits 23:16 first, then 15:8, then 7:0, each MSB first. No other opcode carries an address.
- R3: After the header, 00h dummy bytes are sent: one for 0Bh, three for ABh, two for 9Fh, and none for any other opcode.
- R4: For 01h, 02h, C7h and D8h, a one-byte transaction carrying 06h is sent first, framed by its own chip-select low period.
- R5: Opcode 02h sends min(req_len+1, 256) bytes taken from the write stream. Opcode 01h sends exactly one byte from it. No other command takes write-stream bytes.
- R6: Opcodes 03h, 0Bh, 05h, ABh and 9Fh (when requested directly) clock in req_len+1 bytes and deliver them in order on the read stream. rd_data holds steady while rd_valid is high and rd_ready is low.
- R7: The serial clock high time is HALF_READ cycles for 03h, HALF_FAST cycles for 0Bh and HALF_OTHER cycles for every other command, including the inserted write-enable and status reads. The defaults are 5, 3 and 4 cycles.
- R8: Mode 0 is used: the serial clock is low whenever chip select is high, MOSI is stable while the clock is high, and MISO is sampled on the rising clock.
- R9: After 01h, 02h, C7h or D8h, the sequencer issues separate 05h transactions, each with one read byte. It stops when bit 0 of that byte is 0. `done` comes only after that final status read.
- R10: Chip select stays high for at least CS_GAP system cycles between transactions.
- R11: A select code of 11 or above produces a `done` pulse with no chip-select activity.
- R12: After reset, chip select is high, the serial clock is low and req_ready is high. req_ready is high only while idle, and `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_sel | input | 4 | Command select code |
| req_addr | input | 24 | Memory address |
| req_len | input | LEN_W | Data byte count minus one |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Write stream byte taken |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Read stream byte valid |
| rd_ready | input | 1 | Read stream consumer ready |
| rd_data | output | 8 | Read stream byte |
| done | output | 1 | One-cycle command completion pulse |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory |

## Verification
A wrong phase or byte index shows up at the serial pins within one byte time: a misplaced opcode, address, dummy or data byte, or a transaction with the wrong length seen at the next chip-select rise. A wrong step or poll decision shows up as a missing write-enable or status transaction before `done`. A lost or doubled read byte breaks the in-order read stream at the next handshake. A wrong clock class changes the measured high time of the serial clock on the second byte of the transaction.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

    localparam int SEL_W = 4;

    localparam logic [SEL_W-1:0] SEL_WREN = 4'd0;
    localparam logic [SEL_W-1:0] SEL_RDSR = 4'd2;

    typedef enum logic [1:0] {DK_NONE, DK_READ, DK_WRITE, DK_ONE} dkind_e;
    typedef enum logic [1:0] {CK_OTHER, CK_READ, CK_FAST} ckclass_e;

    typedef struct packed {
        logic        valid;
        logic [7:0]  opcode;
        logic [1:0]  addr_n;
        logic [1:0]  dummy_n;
        dkind_e      dkind;
        logic        modifies;
        ckclass_e    ck;
    } op_info_t;

    typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_GO, ST_WAIT, ST_GAP, ST_DONE} seq_st_e;
    typedef enum logic [1:0] {STEP_WEN, STEP_MAIN, STEP_POLL} step_e;
    typedef enum logic [1:0] {PH_OP, PH_ADDR, PH_DUMMY, PH_DATA} phase_e;

endpackage

// File: rtl/sflash_op_table.sv
module sflash_op_table
    import sflash_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output op_info_t         info
);
    always_comb begin
        info = '{valid: 1'b1, opcode: 8'h00, addr_n: 2'd0, dummy_n: 2'd0,
                 dkind: DK_NONE, modifies: 1'b0, ck: CK_OTHER};
        case (sel)
            4'd0:  info.opcode = 8'h06;
            4'd1:  info.opcode = 8'h04;
            4'd2:  begin info.opcode = 8'h05; info.dkind = DK_READ; end
            4'd3:  begin info.opcode = 8'h03; info.addr_n = 2'd3; info.dkind = DK_READ; info.ck = CK_READ; end
            4'd4:  begin info.opcode = 8'hAB; info.dummy_n = 2'd3; info.dkind = DK_READ; end
            4'd5:  begin info.opcode = 8'h0B; info.addr_n = 2'd3; info.dummy_n = 2'd1; info.dkind = DK_READ; info.ck = CK_FAST; end
            4'd6:  begin info.opcode = 8'h01; info.dkind = DK_ONE; info.modifies = 1'b1; end
            4'd7:  begin info.opcode = 8'h02; info.addr_n = 2'd3; info.dkind = DK_WRITE; info.modifies = 1'b1; end
            4'd8:  begin info.opcode = 8'hC7; info.modifies = 1'b1; end
            4'd9:  begin info.opcode = 8'hD8; info.addr_n = 2'd3; info.modifies = 1'b1; end
            4'd10: begin info.opcode = 8'h9F; info.dummy_n = 2'd2; info.dkind = DK_READ; end
            default: info.valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/sflash_byte_shifter.sv
module sflash_byte_shifter #(
    parameter int HW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    tx,
    input  logic [HW-1:0] half,
    input  logic          miso,
    output logic          busy,
    output logic          done,
    output logic [7:0]    rx,
    output logic          sclk,
    output logic          mosi
);
    typedef struct packed {
        logic          busy;
        logic          done;
        logic          sclk;
        logic          mosi;
        logic [2:0]    bitn;
        logic [HW-1:0] half;
        logic [HW-1:0] hcnt;
        logic [7:0]    sh;
        logic [7:0]    rx;
    } eng_t;

    eng_t q, n;

    always_comb begin
        n = q;
        n.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                n.busy = 1'b1;
                n.sclk = 1'b0;
                n.sh   = tx;
                n.mosi = tx[7];
                n.half = half;
                n.hcnt = half - 1'b1;
                n.bitn = 3'd0;
            end
        end else if (q.hcnt != '0) begin
            n.hcnt = q.hcnt - 1'b1;
        end else begin
            n.hcnt = q.half - 1'b1;
            if (!q.sclk) begin
                n.sclk = 1'b1;
                n.rx   = {q.rx[6:0], miso};
            end else begin
                n.sclk = 1'b0;
                if (q.bitn == 3'd7) begin
                    n.busy = 1'b0;
                    n.done = 1'b1;
                end else begin
                    n.bitn = q.bitn + 3'd1;
                    n.sh   = {q.sh[6:0], 1'b0};
                    n.mosi = q.sh[6];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy = q.busy;
    assign done = q.done;
    assign rx   = q.rx;
    assign sclk = q.sclk;
    assign mosi = q.mosi;
endmodule

// File: rtl/sflash_cmd_seq.sv
module sflash_cmd_seq
    import sflash_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int HALF_READ  = 5,
    parameter int HALF_FAST  = 3,
    parameter int HALF_OTHER = 4,
    parameter int CS_GAP     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [SEL_W-1:0] req_sel,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             spi_cs_n,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int HMAX_A = (HALF_READ > HALF_FAST) ? HALF_READ : HALF_FAST;
    localparam int HMAX   = (HMAX_A > HALF_OTHER) ? HMAX_A : HALF_OTHER;
    localparam int HW     = $clog2(HMAX + 1);
    localparam int GW     = (CS_GAP > 1) ? $clog2(CS_GAP + 1) : 1;
    localparam int RW     = LEN_W + 1;
    localparam logic [RW-1:0] WR_MAX = RW'(256);

    typedef struct packed {
        seq_st_e          st;
        step_e            step;
        phase_e           phase;
        logic [1:0]       idx;
        logic [RW-1:0]    rem;
        logic [SEL_W-1:0] sel;
        logic [23:0]      addr;
        logic [LEN_W-1:0] len;
        logic             cs_n;
        logic [GW-1:0]    gap;
        logic             rdv;
        logic [7:0]       rdd;
        logic             busy_bit;
        logic             done;
    } seq_t;

    seq_t q, n;

    logic [SEL_W-1:0] cur_sel;
    op_info_t         info;
    logic             eng_start, eng_busy, eng_done;
    logic [7:0]       eng_tx, eng_rx;
    logic [HW-1:0]    half;
    logic             last;
    logic [RW-1:0]    len_p1;

    always_comb begin
        if (q.st == ST_IDLE)          cur_sel = req_sel;
        else if (q.step == STEP_WEN)  cur_sel = SEL_WREN;
        else if (q.step == STEP_POLL) cur_sel = SEL_RDSR;
        else                          cur_sel = q.sel;
    end

    sflash_op_table u_table (.sel(cur_sel), .info(info));

    always_comb begin
        case (info.ck)
            CK_READ: half = HW'(HALF_READ);
            CK_FAST: half = HW'(HALF_FAST);
            default: half = HW'(HALF_OTHER);
        endcase
    end

    sflash_byte_shifter #(.HW(HW)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .tx(eng_tx), .half(half),
        .miso(spi_miso), .busy(eng_busy), .done(eng_done), .rx(eng_rx),
        .sclk(spi_sclk), .mosi(spi_mosi)
    );

    assign len_p1 = {1'b0, q.len} + RW'(1);

    always_comb begin
        n         = q;
        n.done    = 1'b0;
        eng_start = 1'b0;
        eng_tx    = 8'h00;
        wr_ready  = 1'b0;
        last      = 1'b0;
        if (q.rdv && rd_ready) n.rdv = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    n.sel  = req_sel;
                    n.addr = req_addr;
                    n.len  = req_len;
                    if (!info.valid) n.st = ST_DONE;
                    else begin
                        n.step = info.modifies ? STEP_WEN : STEP_MAIN;
                        n.st   = ST_SETUP;
                    end
                end
            end
            ST_SETUP: begin
                n.phase = PH_OP;
                n.idx   = 2'd0;
                case (info.dkind)
                    DK_READ:  n.rem = (q.step == STEP_POLL) ? RW'(1) : len_p1;
                    DK_WRITE: n.rem = (len_p1 > WR_MAX) ? WR_MAX : len_p1;
                    DK_ONE:   n.rem = RW'(1);
                    default:  n.rem = '0;
                endcase
                n.cs_n = 1'b0;
                n.st   = ST_GO;
            end
            ST_GO: begin
                case (q.phase)
                    PH_OP:    begin eng_tx = info.opcode; eng_start = !eng_busy; end
                    PH_ADDR:  begin
                        eng_tx = (q.idx == 2'd0) ? q.addr[23:16] :
                                 (q.idx == 2'd1) ? q.addr[15:8] : q.addr[7:0];
                        eng_start = !eng_busy;
                    end
                    PH_DUMMY: eng_start = !eng_busy;
                    default: begin
                        if (info.dkind == DK_READ) begin
                            eng_start = !eng_busy && !q.rdv;
                        end else begin
                            wr_ready  = !eng_busy && wr_valid;
                            eng_tx    = wr_data;
                            eng_start = !eng_busy && wr_valid;
                        end
                    end
                endcase
                if (eng_start) n.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (eng_done) begin
                    case (q.phase)
                        PH_OP: begin
                            if (info.addr_n != 2'd0)       begin n.phase = PH_ADDR;  n.idx = 2'd0; end
                            else if (info.dummy_n != 2'd0) begin n.phase = PH_DUMMY; n.idx = 2'd0; end
                            else if (q.rem != '0)          n.phase = PH_DATA;
                            else                           last = 1'b1;
                        end
                        PH_ADDR: begin
                            if (q.idx != info.addr_n - 2'd1) n.idx = q.idx + 2'd1;
                            else if (info.dummy_n != 2'd0)   begin n.phase = PH_DUMMY; n.idx = 2'd0; end
                            else if (q.rem != '0)            n.phase = PH_DATA;
                            else                             last = 1'b1;
                        end
                        PH_DUMMY: begin
                            if (q.idx != info.dummy_n - 2'd1) n.idx = q.idx + 2'd1;
                            else if (q.rem != '0)             n.phase = PH_DATA;
                            else                              last = 1'b1;
                        end
                        default: begin
                            if (info.dkind == DK_READ) begin
                                if (q.step == STEP_POLL) n.busy_bit = eng_rx[0];
                                else begin
                                    n.rdd = eng_rx;
                                    n.rdv = 1'b1;
                                end
                            end
                            n.rem = q.rem - RW'(1);
                            if (q.rem == RW'(1)) last = 1'b1;
                        end
                    endcase
                    if (last) begin
                        n.cs_n = 1'b1;
                        n.gap  = GW'(CS_GAP - 1);
                        n.st   = ST_GAP;
                    end else begin
                        n.st = ST_GO;
                    end
                end
            end
            ST_GAP: begin
                if (q.gap != '0) n.gap = q.gap - 1'b1;
                else begin
                    case (q.step)
                        STEP_WEN: begin n.step = STEP_MAIN; n.st = ST_SETUP; end
                        STEP_MAIN: begin
                            if (info.modifies) begin n.step = STEP_POLL; n.st = ST_SETUP; end
                            else n.st = ST_DONE;
                        end
                        default: n.st = q.busy_bit ? ST_SETUP : ST_DONE;
                    endcase
                end
            end
            default: begin
                n.done = 1'b1;
                n.st   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.step <= STEP_MAIN;
            q.cs_n <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rd_valid  = q.rdv;
    assign rd_data   = q.rdd;
    assign done      = q.done;
    assign spi_cs_n  = q.cs_n;
endmodule

// File: rtl/sflash_cmd_seq_chk.sv
module sflash_cmd_seq_chk #(
    parameter int CS_GAP = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data,
    input logic       done,
    input logic       spi_cs_n,
    input logic       spi_sclk,
    input logic       spi_mosi
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            hi_cnt <= 16'hFFFF;
        else if (!spi_cs_n)    hi_cnt <= 16'd0;
        else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R8
    AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_cs_n); // R12
    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (hi_cnt >= 16'(CS_GAP))); // R10
endmodule

bind sflash_cmd_seq sflash_cmd_seq_chk #(.CS_GAP(CS_GAP)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .done(done), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
);

// File: tb/sflash_cmd_seq_test.sv
`timescale 1ns/1ps
module sflash_cmd_seq_test;
    localparam real TCK = 5.0;
    localparam int  GAP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [3:0]  req_sel = '0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        wr_valid = 1'b0, wr_ready;
    logic [7:0]  wr_data = '0;
    logic        rd_valid, rd_ready = 1'b1;
    logic [7:0]  rd_data;
    logic        done, spi_cs_n, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0, fails = 0, cyc = 0, txns = 0;
    logic [7:0] exp_b[$];
    int         exp_len[$];
    logic [7:0] exp_rd[$];
    logic [7:0] wq[$];

    sflash_cmd_seq uut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] b_opc(input int s);
        case (s)
            0: return 8'h06; 1: return 8'h04; 2: return 8'h05; 3: return 8'h03;
            4: return 8'hAB; 5: return 8'h0B; 6: return 8'h01; 7: return 8'h02;
            8: return 8'hC7; 9: return 8'hD8; default: return 8'h9F;
        endcase
    endfunction
    function automatic int b_an(input logic [7:0] o);
        return (o == 8'h03 || o == 8'h0B || o == 8'h02 || o == 8'hD8) ? 3 : 0;
    endfunction
    function automatic int b_dn(input logic [7:0] o);
        return (o == 8'h0B) ? 1 : (o == 8'hAB) ? 3 : (o == 8'h9F) ? 2 : 0;
    endfunction
    function automatic int b_half(input logic [7:0] o);
        return (o == 8'h03) ? 5 : (o == 8'h0B) ? 3 : 4;
    endfunction
    function automatic bit b_mod(input logic [7:0] o);
        return (o == 8'h01 || o == 8'h02 || o == 8'hC7 || o == 8'hD8);
    endfunction

    // memory model
    int         busy_left = 0;
    int         bitc = 0, nby = 0, hdr = 1;
    logic [7:0] shin = 0, opc = 0;
    realtime    rise_t = 0, cs_rise_t = 0;
    bit         seen_fall = 0;

    function automatic logic [7:0] mem_out(input logic [7:0] o, input int k);
        if (o == 8'h05) return (busy_left > 0) ? 8'h41 : 8'h40;
        return 8'((8'h3C + k * 7) ^ o);
    endfunction

    always @(negedge spi_cs_n) begin
        if (seen_fall)
            chk(($realtime - cs_rise_t) >= GAP * TCK, "R10 cs gap", int'(($realtime - cs_rise_t) / TCK), GAP);
        seen_fall = 1; bitc = 0; nby = 0; hdr = 1; spi_miso = 1'b0; txns++;
    end

    always @(posedge spi_cs_n) begin
        if (seen_fall) begin
            cs_rise_t = $realtime;
            if (exp_len.size() == 0) chk(0, "R4 unexpected transaction", nby, 0);
            else begin
                int e;
                e = exp_len.pop_front();
                chk(nby == e, "R4 transaction length", nby, e);
            end
            if (opc == 8'h05 && busy_left > 0) busy_left--;
            if (b_mod(opc)) busy_left = 2;
        end
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            rise_t = $realtime;
            shin = {shin[6:0], spi_mosi};
            bitc++;
            if (bitc % 8 == 0) begin
                string tag;
                nby++;
                if (nby == 1) begin
                    opc = shin;
                    hdr = 1 + b_an(shin) + b_dn(shin);
                end
                tag = (nby == 1) ? "R1 opcode" : (nby <= 1 + b_an(opc)) ? "R2 address" :
                      (nby <= hdr) ? "R3 dummy" : "R5 data";
                if (exp_b.size() == 0) chk(0, tag, shin, 0);
                else begin
                    logic [7:0] e;
                    e = exp_b.pop_front();
                    chk(shin == e, tag, shin, e);
                end
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            if (bitc == 9)
                chk(($realtime - rise_t) == b_half(opc) * TCK, "R7 sclk high time",
                    int'(($realtime - rise_t) / TCK), b_half(opc));
            if (bitc / 8 >= hdr) begin
                logic [7:0] ob;
                ob = mem_out(opc, bitc / 8 - hdr);
                spi_miso = ob[7 - bitc % 8];
            end
        end
    end

    // write stream driver and read stream monitor
    always @(negedge clk) begin
        cyc++;
        rd_ready = (cyc % 5) != 0;
        if (rd_valid && rd_ready) begin
            if (exp_rd.size() == 0) chk(0, "R6 extra read byte", rd_data, 0);
            else begin
                logic [7:0] e;
                e = exp_rd.pop_front();
                chk(rd_data == e, "R6 read byte", rd_data, e);
            end
        end
        if (wq.size() > 0) begin wr_valid = 1'b1; wr_data = wq[0]; end
        else wr_valid = 1'b0;
        #1;
        if (wr_valid && wr_ready) void'(wq.pop_front());
    end

    task automatic run_cmd(input int s, input logic [23:0] a, input int len);
        logic [7:0] o;
        int         nd;
        o = b_opc(s);
        if (s <= 10) begin
            if (b_mod(o)) begin exp_b.push_back(8'h06); exp_len.push_back(1); end
            exp_b.push_back(o);
            if (b_an(o) == 3) begin
                exp_b.push_back(a[23:16]); exp_b.push_back(a[15:8]); exp_b.push_back(a[7:0]);
            end
            for (int i = 0; i < b_dn(o); i++) exp_b.push_back(8'h00);
            nd = 0;
            if (o == 8'h02) nd = (len + 1 > 256) ? 256 : len + 1;
            else if (o == 8'h01) nd = 1;
            for (int i = 0; i < nd; i++) begin
                logic [7:0] w;
                w = 8'(i * 13 + s);
                wq.push_back(w); exp_b.push_back(w);
            end
            if (o == 8'h03 || o == 8'h0B || o == 8'h05 || o == 8'hAB || o == 8'h9F) begin
                for (int i = 0; i <= len; i++) begin
                    exp_b.push_back(8'h00);
                    exp_rd.push_back((o == 8'h05) ? 8'h40 : 8'((8'h3C + i * 7) ^ o));
                end
                nd = len + 1;
            end
            exp_len.push_back(1 + b_an(o) + b_dn(o) + nd);
            if (b_mod(o))
                for (int i = 0; i < 3; i++) begin
                    exp_b.push_back(8'h05); exp_b.push_back(8'h00); exp_len.push_back(2);
                end
        end
        @(negedge clk);
        req_valid = 1'b1; req_sel = 4'(s); req_addr = a; req_len = 16'(len);
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        chk(exp_b.size() == 0 && exp_len.size() == 0, "R9 done after all transactions",
            exp_b.size(), 0);
        repeat (20) @(negedge clk);
        chk(exp_rd.size() == 0 && wq.size() == 0, "R6 R5 streams drained",
            exp_rd.size() + wq.size(), 0);
        chk(!done, "R12 done single cycle", done, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R12 reset cs_n", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R12 R8 reset sclk", spi_sclk, 0);
        chk(req_ready == 1'b1 && rd_valid == 1'b0 && done == 1'b0, "R12 reset outputs",
            {req_ready, rd_valid, done}, 3'b100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_cmd(3, 24'h123456, 4);     // R2 R6 R7 read
        run_cmd(5, 24'hABCDEF, 2);     // R3 R7 fast read
        run_cmd(4, 24'h0, 0);          // R3 three dummies
        run_cmd(10, 24'h0, 2);         // R3 two dummies
        run_cmd(2, 24'h0, 1);          // R6 direct status read
        run_cmd(7, 24'h000100, 3);     // R4 R5 R9 write bytes
        run_cmd(7, 24'h0A0B0C, 299);   // R5 clamp to 256
        run_cmd(6, 24'h0, 5);          // R5 one status byte
        run_cmd(8, 24'h0, 0);          // R4 R9 erase all
        run_cmd(9, 24'h0F0000, 0);     // R2 R4 sector erase
        run_cmd(0, 24'h0, 0);          // R1 write enable alone
        run_cmd(1, 24'h0, 0);          // R1 write disable
        begin
            int t0;
            t0 = txns;
            run_cmd(12, 24'h0, 0);     // R11 invalid select
            chk(txns == t0, "R11 no chip select activity", txns - t0, 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule